// File: doc/BRIEF.md
# Banked Register Window Access Sequencer

This block gives a host flat access to a register window that is split into several banks. The window is only a few 16-bit words wide. A host request carries one flat register number. The number holds a bank field and a byte offset, so the host never touches the bank selector itself. For each normal request the block runs one indivisible four-step sequence on the window:

1. Read the bank selector word and keep its bank bits.
2. Write the target bank into the selector.
3. Perform the data read or write.
4. Write the kept bank back.

The bank context the host had before the request is therefore left exactly as it was. A fast request skips the bank switching. It performs only the data access, in whatever bank is currently selected.

Requests use a valid/ready handshake. A request is taken on a clock edge where both `req_valid` and `req_ready` are high. The request fields must be held stable while `req_valid` is high and `req_ready` is low. Once a request is taken, `req_ready` stays low until the response is issued, so the host is back-pressured for the whole sequence. The response is a single-cycle `rsp_valid` pulse with no back-pressure, and the host must take it when it comes. In the cycle of that pulse `req_ready` is already high again, so a new request can be taken on the same edge.

The window side is a plain synchronous word bus. There is one transaction per clock, and read data appears on the cycle after the read strobe. The bank selector lives at word 7 of the window.

Top module: `banked_window_seq`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `req_ready` is 1 and `rsp_valid`, `win_we` and `win_re` are 0.
- R2: A normal request takes its target bank from `req_addr[6:4]` and its word index from `req_addr[3:1]`. Bit 0 of `req_addr` has no effect on which word is reached.
- R3: A normal request taken at edge N drives the window over four consecutive cycles:
  - N+1: a read of word 7.
  - N+2: a write of word 7 with the target bank, zero-extended to 16 bits.
  - N+3: the data read or write at the word index.
  - N+4: a write of word 7 with the saved bank.
- R4: The saved bank is bits [2:0] of the word 7 value read at N+1, zero-extended. Higher bits of that value are not restored.
- R5: A fast request drives exactly one window transaction, in the cycle after acceptance, at word index `req_addr[3:1]`. `req_addr[6:4]` has no effect, and the bank selector is not otherwise read or written.
- R6: `req_ready` is low from the cycle after acceptance until the response cycle. No window transaction occurs while `req_ready` is high.
- R7: `rsp_valid` is a one-cycle pulse. For a normal request it comes in cycle N+5, and for a fast request in cycle N+3.
- R8: A read response carries on `rsp_rdata` the 16-bit word returned by the data read. A write puts `req_wdata` onto the window unchanged.
- R9: `win_we` and `win_re` are never high in the same cycle.
- R10: In a normal request whose word index is 7, the data access still goes to word 7, and the restore write follows it. The bank selector ends holding the saved bank.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Block can take a request |
| req_addr | input | 7 | Flat register number: bank in [6:4], byte offset in [3:0] |
| req_write | input | 1 | 1 = write, 0 = read |
| req_fast | input | 1 | 1 = data access only, no bank switching |
| req_wdata | input | 16 | Write data |
| rsp_valid | output | 1 | One-cycle response pulse |
| rsp_rdata | output | 16 | Read data, valid with `rsp_valid` for reads |
| win_addr | output | 3 | Window word index |
| win_wdata | output | 16 | Window write data |
| win_we | output | 1 | Window write strobe |
| win_re | output | 1 | Window read strobe |
| win_rdata | input | 16 | Window read data, one cycle after `win_re` |

## Verification
Two things can fall in the same cycle: the response pulse of one request and the acceptance of the next. The bench provokes this by holding `req_valid` high across two requests and changing the fields once the first is taken. It then checks three things:
- `req_ready` is high in the response cycle of the first request.
- The very next cycle is the save read of the second request.
- The first request's read data is intact.

The data read and the restore write also share a cycle with the capture of read data. The bench checks this by comparing the returned word against its own window model, while the restore value lands in the selector.

// File: rtl/bws_pkg.sv
package bws_pkg;
  typedef enum logic [2:0] {
    ST_IDLE    = 3'd0,
    ST_SAVE    = 3'd1,
    ST_SELECT  = 3'd2,
    ST_ACCESS  = 3'd3,
    ST_RESTORE = 3'd4,
    ST_FAST    = 3'd5,
    ST_FWAIT   = 3'd6
  } seq_state_t;
endpackage

// File: rtl/bws_addr_split.sv
module bws_addr_split #(
  parameter int BANK_W = 3,
  parameter int IDX_W  = 3,
  localparam int AW    = BANK_W + IDX_W + 1
) (
  input  logic [AW-1:0]     flat_addr,
  output logic [BANK_W-1:0] bank,
  output logic [IDX_W-1:0]  word_idx
);
  // Bit 0 is a byte offset inside a 16-bit word and is dropped.
  assign word_idx = flat_addr[IDX_W:1];
  assign bank     = flat_addr[AW-1 -: BANK_W];
endmodule

// File: rtl/bws_seq_fsm.sv
module bws_seq_fsm
  import bws_pkg::*;
#(
  parameter int DW     = 16,
  parameter int BANK_W = 3,
  parameter int IDX_W  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic              req_fast,
  input  logic [DW-1:0]     req_wdata,
  input  logic [BANK_W-1:0] req_bank,
  input  logic [IDX_W-1:0]  req_idx,
  input  logic [DW-1:0]     win_rdata,
  output logic              req_ready,
  output seq_state_t        state,
  output logic [BANK_W-1:0] tgt_bank,
  output logic [BANK_W-1:0] saved_bank,
  output logic [IDX_W-1:0]  tgt_idx,
  output logic [DW-1:0]     tgt_wdata,
  output logic              tgt_write,
  output logic              done
);
  seq_state_t state_nx;
  logic       accept;

  assign req_ready = (state == ST_IDLE);
  assign accept    = req_valid && req_ready;
  assign done      = (state == ST_RESTORE) || (state == ST_FWAIT);

  always_comb begin
    state_nx = state;
    unique case (state)
      ST_IDLE:    if (accept) state_nx = req_fast ? ST_FAST : ST_SAVE;
      ST_SAVE:    state_nx = ST_SELECT;
      ST_SELECT:  state_nx = ST_ACCESS;
      ST_ACCESS:  state_nx = ST_RESTORE;
      ST_RESTORE: state_nx = ST_IDLE;
      ST_FAST:    state_nx = ST_FWAIT;
      ST_FWAIT:   state_nx = ST_IDLE;
      default:    state_nx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= ST_IDLE;
      tgt_bank   <= '0;
      tgt_idx    <= '0;
      tgt_wdata  <= '0;
      tgt_write  <= 1'b0;
      saved_bank <= '0;
    end else begin
      state <= state_nx;
      if (accept) begin
        tgt_bank  <= req_bank;
        tgt_idx   <= req_idx;
        tgt_wdata <= req_wdata;
        tgt_write <= req_write;
      end
      // The selector read issued in ST_SAVE returns during ST_SELECT.
      if (state == ST_SELECT) saved_bank <= win_rdata[BANK_W-1:0];
    end
  end
endmodule

// File: rtl/bws_win_drive.sv
module bws_win_drive
  import bws_pkg::*;
#(
  parameter int DW       = 16,
  parameter int BANK_W   = 3,
  parameter int IDX_W    = 3,
  parameter int SEL_WORD = 7
) (
  input  seq_state_t        state,
  input  logic [BANK_W-1:0] tgt_bank,
  input  logic [BANK_W-1:0] saved_bank,
  input  logic [IDX_W-1:0]  tgt_idx,
  input  logic [DW-1:0]     tgt_wdata,
  input  logic              tgt_write,
  output logic [IDX_W-1:0]  win_addr,
  output logic [DW-1:0]     win_wdata,
  output logic              win_we,
  output logic              win_re
);
  localparam logic [IDX_W-1:0] SEL_IDX = IDX_W'(SEL_WORD);
  localparam int               PAD_W   = DW - BANK_W;

  always_comb begin
    win_addr  = '0;
    win_wdata = '0;
    win_we    = 1'b0;
    win_re    = 1'b0;
    unique case (state)
      ST_SAVE: begin
        win_addr = SEL_IDX;
        win_re   = 1'b1;
      end
      ST_SELECT: begin
        win_addr  = SEL_IDX;
        win_wdata = {{PAD_W{1'b0}}, tgt_bank};
        win_we    = 1'b1;
      end
      ST_ACCESS, ST_FAST: begin
        win_addr  = tgt_idx;
        win_wdata = tgt_wdata;
        win_we    = tgt_write;
        win_re    = !tgt_write;
      end
      ST_RESTORE: begin
        win_addr  = SEL_IDX;
        win_wdata = {{PAD_W{1'b0}}, saved_bank};
        win_we    = 1'b1;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/bws_rsp_stage.sv
module bws_rsp_stage #(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          done,
  input  logic          was_write,
  input  logic [DW-1:0] win_rdata,
  output logic          rsp_valid,
  output logic [DW-1:0] rsp_rdata
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= done;
      if (done && !was_write) rsp_rdata <= win_rdata;
    end
  end
endmodule

// File: rtl/banked_window_seq.sv
module banked_window_seq
  import bws_pkg::*;
#(
  parameter int DW       = 16,
  parameter int BANK_W   = 3,
  parameter int IDX_W    = 3,
  parameter int SEL_WORD = 7,
  localparam int AW      = BANK_W + IDX_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [AW-1:0]    req_addr,
  input  logic             req_write,
  input  logic             req_fast,
  input  logic [DW-1:0]    req_wdata,
  output logic             rsp_valid,
  output logic [DW-1:0]    rsp_rdata,
  output logic [IDX_W-1:0] win_addr,
  output logic [DW-1:0]    win_wdata,
  output logic             win_we,
  output logic             win_re,
  input  logic [DW-1:0]    win_rdata
);
  logic [BANK_W-1:0] req_bank, tgt_bank, saved_bank;
  logic [IDX_W-1:0]  req_idx, tgt_idx;
  logic [DW-1:0]     tgt_wdata;
  logic              tgt_write, done;
  seq_state_t        state;

  bws_addr_split #(.BANK_W(BANK_W), .IDX_W(IDX_W)) u_split (
    .flat_addr (req_addr),
    .bank      (req_bank),
    .word_idx  (req_idx)
  );

  bws_seq_fsm #(.DW(DW), .BANK_W(BANK_W), .IDX_W(IDX_W)) u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_write  (req_write),
    .req_fast   (req_fast),
    .req_wdata  (req_wdata),
    .req_bank   (req_bank),
    .req_idx    (req_idx),
    .win_rdata  (win_rdata),
    .req_ready  (req_ready),
    .state      (state),
    .tgt_bank   (tgt_bank),
    .saved_bank (saved_bank),
    .tgt_idx    (tgt_idx),
    .tgt_wdata  (tgt_wdata),
    .tgt_write  (tgt_write),
    .done       (done)
  );

  bws_win_drive #(.DW(DW), .BANK_W(BANK_W), .IDX_W(IDX_W), .SEL_WORD(SEL_WORD)) u_drive (
    .state      (state),
    .tgt_bank   (tgt_bank),
    .saved_bank (saved_bank),
    .tgt_idx    (tgt_idx),
    .tgt_wdata  (tgt_wdata),
    .tgt_write  (tgt_write),
    .win_addr   (win_addr),
    .win_wdata  (win_wdata),
    .win_we     (win_we),
    .win_re     (win_re)
  );

  bws_rsp_stage #(.DW(DW)) u_rsp (
    .clk       (clk),
    .rst_n     (rst_n),
    .done      (done),
    .was_write (tgt_write),
    .win_rdata (win_rdata),
    .rsp_valid (rsp_valid),
    .rsp_rdata (rsp_rdata)
  );
endmodule

// File: rtl/bws_checker.sv
module bws_checker #(
  parameter int DW       = 16,
  parameter int BANK_W   = 3,
  parameter int IDX_W    = 3,
  parameter int SEL_WORD = 7,
  localparam int AW      = BANK_W + IDX_W + 1
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_valid,
  input logic             req_ready,
  input logic [AW-1:0]    req_addr,
  input logic             req_fast,
  input logic             rsp_valid,
  input logic [IDX_W-1:0] win_addr,
  input logic [DW-1:0]    win_wdata,
  input logic             win_we,
  input logic             win_re
);
  localparam logic [IDX_W-1:0] SEL_IDX = IDX_W'(SEL_WORD);

  logic acc_norm, acc_fast;
  assign acc_norm = req_valid && req_ready && !req_fast;
  assign acc_fast = req_valid && req_ready && req_fast;

  p_idle_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> !(win_we || win_re));

  p_busy_after_accept_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);

  p_single_op_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(win_we && win_re));

  p_save_first_r3: assert property (@(posedge clk) disable iff (!rst_n)
    acc_norm |=> (win_re && !win_we && win_addr == SEL_IDX));

  p_select_bank_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $past(acc_norm, 2) |-> (win_we && win_addr == SEL_IDX &&
      win_wdata[BANK_W-1:0] == $past(req_addr[AW-1 -: BANK_W], 2) &&
      win_wdata[DW-1:BANK_W] == '0));

  p_restore_zext_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $past(acc_norm, 4) |-> (win_we && win_addr == SEL_IDX &&
      win_wdata[DW-1:BANK_W] == '0));

  p_fast_target_r5: assert property (@(posedge clk) disable iff (!rst_n)
    acc_fast |=> ((win_we || win_re) && win_addr == $past(req_addr[IDX_W:1])));

  p_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);
endmodule

bind banked_window_seq bws_checker #(
  .DW(DW), .BANK_W(BANK_W), .IDX_W(IDX_W), .SEL_WORD(SEL_WORD)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .req_addr  (req_addr),
  .req_fast  (req_fast),
  .rsp_valid (rsp_valid),
  .win_addr  (win_addr),
  .win_wdata (win_wdata),
  .win_we    (win_we),
  .win_re    (win_re)
);

// File: tb/banked_window_seq_test.sv
module banked_window_seq_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0, req_fast = 1'b0;
  logic [6:0]  req_addr = '0;
  logic [15:0] req_wdata = '0;
  logic        req_ready, rsp_valid, win_we, win_re;
  logic [15:0] rsp_rdata, win_wdata;
  logic [15:0] win_rdata;
  logic [2:0]  win_addr;

  int n_chk = 0, n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  banked_window_seq uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_write(req_write), .req_fast(req_fast),
    .req_wdata(req_wdata), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .win_addr(win_addr), .win_wdata(win_wdata), .win_we(win_we),
    .win_re(win_re), .win_rdata(win_rdata)
  );

  // Window model: word 7 is the bank selector, words 0..6 are banked.
  logic [15:0] bank_reg;
  logic [15:0] mem [0:7][0:7];
  logic        tr_we   [0:63];
  logic [2:0]  tr_addr [0:63];
  logic [15:0] tr_data [0:63];
  int          tr_n;
  int          both_cnt;

  always @(posedge clk) begin
    if (!rst_n) begin
      bank_reg  <= '0;
      win_rdata <= '0;
      tr_n      <= 0;
      both_cnt  <= 0;
      for (int b = 0; b < 8; b++)
        for (int w = 0; w < 8; w++) mem[b][w] <= '0;
    end else begin
      if (win_we) begin
        if (win_addr == 3'd7) bank_reg <= win_wdata;
        else mem[bank_reg[2:0]][win_addr] <= win_wdata;
      end
      if (win_re)
        win_rdata <= (win_addr == 3'd7) ? bank_reg : mem[bank_reg[2:0]][win_addr];
      if (win_we || win_re) begin
        tr_we[tr_n[5:0]]   <= win_we;
        tr_addr[tr_n[5:0]] <= win_addr;
        tr_data[tr_n[5:0]] <= win_wdata;
        tr_n <= tr_n + 1;
      end
      if (win_we && win_re) both_cnt <= both_cnt + 1;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic chk_op(input string req, input int i, input logic we,
                        input logic [2:0] a, input logic [15:0] d);
    chk(req, {31'd0, tr_we[i]}, {31'd0, we});
    chk(req, {29'd0, tr_addr[i]}, {29'd0, a});
    if (we) chk(req, {16'd0, tr_data[i]}, {16'd0, d});
  endtask

  // Issue one request, wait for its response, count latency from acceptance.
  task automatic do_req(input logic [6:0] a, input logic wr, input logic [15:0] d,
                        input logic fast, output logic [15:0] rd, output int lat,
                        output int base);
    int busy_hi = 0;
    @(negedge clk);
    base = tr_n;
    req_addr = a; req_write = wr; req_wdata = d; req_fast = fast; req_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    lat = 1;
    while (!rsp_valid && lat < 50) begin
      if (req_ready) busy_hi++;
      @(negedge clk);
      lat++;
    end
    rd = rsp_rdata;
    chk("R6 ready low while busy", busy_hi, 0);
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk("R1 ready after reset", {31'd0, req_ready}, 1);
    chk("R1 rsp_valid after reset", {31'd0, rsp_valid}, 0);
    chk("R1 window idle after reset", {30'd0, win_we, win_re}, 0);
  endtask

  task automatic t_fast();
    logic [15:0] rd; int lat, b;
    do_req(7'h0E, 1'b1, 16'h0002, 1'b1, rd, lat, b);
    chk("R7 fast latency", lat, 3);
    chk("R5 fast one op", tr_n - b, 1);
    chk_op("R5 fast selector write", b, 1'b1, 3'd7, 16'h0002);
    do_req(7'h7A, 1'b1, 16'h5A5A, 1'b1, rd, lat, b);
    chk("R5 fast write lands in current bank", {16'd0, mem[2][5]}, 32'h5A5A);
    chk("R5 fast leaves selector", {16'd0, bank_reg}, 2);
    chk("R5 fast one op", tr_n - b, 1);
    do_req(7'h0A, 1'b0, 16'h0000, 1'b1, rd, lat, b);
    chk("R8 fast read data", {16'd0, rd}, 32'h5A5A);
    chk("R7 fast read latency", lat, 3);
  endtask

  task automatic t_normal_write();
    logic [15:0] rd; int lat, b;
    do_req(7'h35, 1'b1, 16'hBEEF, 1'b0, rd, lat, b);
    chk("R7 normal latency", lat, 5);
    chk("R3 four ops", tr_n - b, 4);
    chk_op("R3 save read", b, 1'b0, 3'd7, 16'h0);
    chk_op("R3 select bank", b + 1, 1'b1, 3'd7, 16'h0003);
    chk_op("R8 data write", b + 2, 1'b1, 3'd2, 16'hBEEF);
    chk_op("R3 restore", b + 3, 1'b1, 3'd7, 16'h0002);
    chk("R2 data in bank 3 word 2", {16'd0, mem[3][2]}, 32'hBEEF);
    chk("R3 selector restored", {16'd0, bank_reg}, 2);
  endtask

  task automatic t_normal_read();
    logic [15:0] rd; int lat, b;
    do_req(7'h0E, 1'b1, 16'h0005, 1'b1, rd, lat, b);
    do_req(7'h0C, 1'b1, 16'h1234, 1'b1, rd, lat, b);
    do_req(7'h0E, 1'b1, 16'h0000, 1'b1, rd, lat, b);
    do_req(7'h5D, 1'b0, 16'h0000, 1'b0, rd, lat, b);
    chk("R8 normal read data", {16'd0, rd}, 32'h1234);
    chk_op("R2 select bank 5", b + 1, 1'b1, 3'd7, 16'h0005);
    chk_op("R2 read word 6, bit0 ignored", b + 2, 1'b0, 3'd6, 16'h0);
    chk_op("R3 restore bank 0", b + 3, 1'b1, 3'd7, 16'h0000);
  endtask

  task automatic t_save_mask();
    logic [15:0] rd; int lat, b;
    do_req(7'h0E, 1'b1, 16'hFFF1, 1'b1, rd, lat, b);
    do_req(7'h40, 1'b1, 16'h7777, 1'b0, rd, lat, b);
    chk("R2 data in bank 4 word 0", {16'd0, mem[4][0]}, 32'h7777);
    chk_op("R4 restore only low bits", b + 3, 1'b1, 3'd7, 16'h0001);
    chk("R4 selector after restore", {16'd0, bank_reg}, 32'h0001);
  endtask

  task automatic t_idx7();
    logic [15:0] rd; int lat, b;
    do_req(7'h2E, 1'b1, 16'h00FF, 1'b0, rd, lat, b);
    chk_op("R10 data access to word 7", b + 2, 1'b1, 3'd7, 16'h00FF);
    chk_op("R10 restore follows", b + 3, 1'b1, 3'd7, 16'h0001);
    chk("R10 selector holds saved bank", {16'd0, bank_reg}, 1);
  endtask

  task automatic t_back_to_back();
    int lat, b;
    @(negedge clk);
    b = tr_n;
    req_addr = 7'h5D; req_write = 1'b0; req_fast = 1'b0; req_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    req_addr = 7'h13; req_write = 1'b1; req_wdata = 16'hA5A5;
    lat = 1;
    while (!rsp_valid && lat < 50) begin @(negedge clk); lat++; end
    chk("R7 first response latency", lat, 5);
    chk("R6 ready in response cycle", {31'd0, req_ready}, 1);
    chk("R8 first read data", {16'd0, rsp_rdata}, 32'h1234);
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    chk("R3 next save read immediately", {29'd0, win_re, win_addr}, {29'd0, 1'b1, 3'd7});
    lat = 1;
    while (!rsp_valid && lat < 50) begin @(negedge clk); lat++; end
    chk("R7 second response latency", lat, 5);
    chk("R3 eight ops total", tr_n - b, 8);
    chk_op("R3 second select", b + 5, 1'b1, 3'd7, 16'h0001);
    chk("R2 second write bank 1 word 1", {16'd0, mem[1][1]}, 32'hA5A5);
    chk("R9 no simultaneous strobes", both_cnt, 0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    t_reset();
    t_fast();
    t_normal_write();
    t_normal_read();
    t_save_mask();
    t_idx7();
    t_back_to_back();
    repeat (3) @(negedge clk);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end
endmodule